// File: doc/BRIEF.md
# Symmetric PWM Timer Channel

This block is an 8-bit timer channel that produces a center-aligned PWM waveform on a single output pin. A triangle counter climbs from 0 to 255 and then falls back to 0. It does not jump from the top back to zero, so each pulse sits symmetrically about the bottom of the count. The counter advances only on a clock enable from an internal divider. The divider is set to pass every clock, or one clock in 8, 64, 256 or 1024, or to hold the counter still.

The duty cycle comes from a compare value. Software writes it into a holding register, and the holding register feeds the working comparator only when the counter turns at its top. The pin is driven high or low on the matches, with either polarity. A small correction at the top turn keeps the waveform symmetric when the compare value moves away from 255. Two sticky flags mark the bottom turn and a compare match. Each flag is cleared by a one-cycle clear pulse.

Top module: `pcpwm_timer`

## Requirements
- R1: The divider code `presc_sel` selects the step rate: 1 = every clock, 2 = every 8th clock, 3 = every 64th, 4 = every 256th, 5 = every 1024th. Codes 0, 6 and 7 hold the counter still.
- R2: A new `presc_sel` code restarts the divider. If the new code is first sampled at clock edge E0, the first counter step happens at edge E0+N, where N is the divisor of the new code.
- R3: The counter steps one unit per enable, in the order 0,1,…,255,254,…,1,0,1,…. A full cycle takes 510 steps, so the pin period is N×510 clocks.
- R4: A value written through `cmp_we`/`cmp_wdata` goes into a holding register. The working compare value V takes that value only on the step that leaves count 255.
- R5: With `pol_inv`=0, the pin level after a step to count c is (c ≤ V) if that step went up and (c < V) if it went down. In other words, an up-count match drives the pin low and a down-count match drives it high. Out of reset, before the first step, the level is 0.
- R6: With `pol_inv`=0, V=0 keeps the pin low at all times and V=255 keeps it high at all times.
- R7: With `pol_inv`=1, the pin is the complement of the R5/R6 level. A change of `pol_inv` shows on the pin in the same cycle.
- R8: On the step that leaves 255, the pin takes the up-count match level (low for `pol_inv`=0) whenever the newly loaded V is below 255. This applies even though no match happened, and in particular when V moves away from 255.
- R9: `ovf_flag` sets on the clock edge at which the counter steps to 0.
- R10: `cmp_flag` sets on the clock edge of a step taken while the count equals V.
- R11: A one-cycle high pulse on `ovf_clr` or `cmp_clr` clears the matching flag at that edge. If the flag sets at the same edge, the set wins.
- R12: While `rst_n` is low, the count, V, the holding register, both flags and the internal pin level are all 0. The counter direction is up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| presc_sel | input | 3 | Divider code (R1) |
| pol_inv | input | 1 | 1 selects the inverted pin polarity |
| cmp_we | input | 1 | Write strobe for the compare holding register |
| cmp_wdata | input | 8 | Compare value to write |
| ovf_clr | input | 1 | Clear pulse for the bottom flag |
| cmp_clr | input | 1 | Clear pulse for the compare flag |
| pwm_pin | output | 1 | PWM output |
| ovf_flag | output | 1 | Sticky flag, set when the count reaches 0 |
| cmp_flag | output | 1 | Sticky flag, set on a compare match |

## Verification
The bench targets compare values of 0, 1, 254 and 255, and moves from 255 to a lower value at the top turn. A design without the top-turn correction would leave the pin high for half a period, and a design that mishandles the extremes would emit one-clock glitches at the turns. Writes land at random points in the period. If the holding register were skipped, the pin would change in the middle of a period and the pulse would lose its symmetry. Divider changes are checked against the restart rule, because a divider that does not restart shifts every later step. Clears are issued in the same cycle as new sets, which catches a clear that beats a set.

// File: rtl/pcpwm_pkg.sv
`timescale 1ns/1ps
package pcpwm_pkg;

   localparam int unsigned PS_SEL_W   = 3;
   localparam int unsigned PS_MAX_DIV = 1024;
   localparam int unsigned PS_DIV_W   = $clog2(PS_MAX_DIV) + 1;

   typedef enum logic [PS_SEL_W-1:0] {
      PS_HOLD    = 3'd0,
      PS_DIV1    = 3'd1,
      PS_DIV8    = 3'd2,
      PS_DIV64   = 3'd3,
      PS_DIV256  = 3'd4,
      PS_DIV1024 = 3'd5
   } ps_code_e;

   // Divisor for a selection code; 0 means the counter is held.
   function automatic int unsigned ps_divisor(input logic [PS_SEL_W-1:0] code);
      int unsigned d;
      case (code)
         PS_DIV1:    d = 1;
         PS_DIV8:    d = 8;
         PS_DIV64:   d = 64;
         PS_DIV256:  d = 256;
         PS_DIV1024: d = 1024;
         default:    d = 0;
      endcase
      return d;
   endfunction

endpackage

// File: rtl/pcpwm_prescaler.sv
`timescale 1ns/1ps
module pcpwm_prescaler
   import pcpwm_pkg::*;
#(
   parameter int unsigned SEL_W = PS_SEL_W,
   parameter int unsigned DIV_W = PS_DIV_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SEL_W-1:0] sel,
   output logic             step_en
);

   logic [SEL_W-1:0] sel_q;
   logic [DIV_W-1:0] pcnt;
   logic [DIV_W-1:0] div;
   logic             sel_chg;
   logic             running;
   logic             wrap;

   assign div     = DIV_W'(ps_divisor(sel));
   assign sel_chg = (sel != sel_q);
   assign running = (div != '0);
   assign wrap    = (pcnt == div - DIV_W'(1));
   assign step_en = running && !sel_chg && wrap;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sel_q <= '0;
         pcnt  <= '0;
      end else begin
         sel_q <= sel;
         if (sel_chg || !running || wrap)
            pcnt <= '0;
         else
            pcnt <= pcnt + DIV_W'(1);
      end
   end

endmodule

// File: rtl/pcpwm_counter.sv
`timescale 1ns/1ps
module pcpwm_counter #(
   parameter int unsigned CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step_en,
   output logic [CNT_W-1:0] cnt,
   output logic             cnt_dn,
   output logic             at_top,
   output logic             at_bot
);

   localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   assign at_top = (cnt == TOP);
   assign at_bot = (cnt == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt    <= '0;
         cnt_dn <= 1'b0;
      end else if (step_en) begin
         if (at_top) begin
            cnt    <= TOP - ONE;
            cnt_dn <= 1'b1;
         end else if (at_bot) begin
            cnt    <= ONE;
            cnt_dn <= 1'b0;
         end else if (cnt_dn) begin
            cnt    <= cnt - ONE;
         end else begin
            cnt    <= cnt + ONE;
         end
      end
   end

endmodule

// File: rtl/pcpwm_compare.sv
`timescale 1ns/1ps
module pcpwm_compare #(
   parameter int unsigned CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [CNT_W-1:0] wr_val,
   input  logic             load,
   output logic [CNT_W-1:0] hold_val,
   output logic [CNT_W-1:0] act_val
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hold_val <= '0;
         act_val  <= '0;
      end else begin
         if (wr_en)
            hold_val <= wr_val;
         if (load)
            act_val <= hold_val;
      end
   end

endmodule

// File: rtl/pcpwm_wavegen.sv
`timescale 1ns/1ps
module pcpwm_wavegen #(
   parameter int unsigned CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step_en,
   input  logic [CNT_W-1:0] cnt,
   input  logic             cnt_dn,
   input  logic             at_top,
   input  logic             at_bot,
   input  logic [CNT_W-1:0] act_val,
   input  logic [CNT_W-1:0] hold_val,
   input  logic             pol_inv,
   input  logic             ovf_clr,
   input  logic             cmp_clr,
   output logic             pwm_pin,
   output logic             ovf_flag,
   output logic             cmp_flag
);

   localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

   logic lvl_q;
   logic lvl_d;
   logic hit;
   logic ovf_set;
   logic cmp_set;

   assign hit     = (cnt == act_val);
   assign ovf_set = step_en && cnt_dn && (cnt == CNT_W'(1));
   assign cmp_set = step_en && hit;

   // Level for the non-inverted pin after this step.
   always_comb begin
      lvl_d = lvl_q;
      if (step_en) begin
         if (at_top)
            lvl_d = (hold_val == TOP);      // top turn: take newly loaded value
         else if (at_bot)
            lvl_d = (act_val != '0);        // bottom turn
         else if (hit)
            lvl_d = cnt_dn;                 // up match clears, down match sets
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lvl_q    <= 1'b0;
         ovf_flag <= 1'b0;
         cmp_flag <= 1'b0;
      end else begin
         lvl_q <= lvl_d;
         if (ovf_set)      ovf_flag <= 1'b1;
         else if (ovf_clr) ovf_flag <= 1'b0;
         if (cmp_set)      cmp_flag <= 1'b1;
         else if (cmp_clr) cmp_flag <= 1'b0;
      end
   end

   assign pwm_pin = lvl_q ^ pol_inv;

endmodule

// File: rtl/pcpwm_timer.sv
`timescale 1ns/1ps
module pcpwm_timer
   import pcpwm_pkg::*;
#(
   parameter int unsigned CNT_W = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [PS_SEL_W-1:0] presc_sel,
   input  logic                pol_inv,
   input  logic                cmp_we,
   input  logic [CNT_W-1:0]    cmp_wdata,
   input  logic                ovf_clr,
   input  logic                cmp_clr,
   output logic                pwm_pin,
   output logic                ovf_flag,
   output logic                cmp_flag
);

   generate
      if (CNT_W < 2 || CNT_W > 16) begin : g_bad_width
         $error("pcpwm_timer: CNT_W must lie in 2..16");
      end
      if (PS_DIV_W < 2) begin : g_bad_div
         $error("pcpwm_timer: divider width too small");
      end
   endgenerate

   logic             step_en;
   logic [CNT_W-1:0] cnt;
   logic             cnt_dn;
   logic             at_top;
   logic             at_bot;
   logic [CNT_W-1:0] hold_val;
   logic [CNT_W-1:0] act_val;

   pcpwm_prescaler #(.SEL_W(PS_SEL_W), .DIV_W(PS_DIV_W)) u_presc (
      .clk     (clk),
      .rst_n   (rst_n),
      .sel     (presc_sel),
      .step_en (step_en)
   );

   pcpwm_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .step_en (step_en),
      .cnt     (cnt),
      .cnt_dn  (cnt_dn),
      .at_top  (at_top),
      .at_bot  (at_bot)
   );

   pcpwm_compare #(.CNT_W(CNT_W)) u_cmp (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (cmp_we),
      .wr_val   (cmp_wdata),
      .load     (step_en && at_top),
      .hold_val (hold_val),
      .act_val  (act_val)
   );

   pcpwm_wavegen #(.CNT_W(CNT_W)) u_wave (
      .clk      (clk),
      .rst_n    (rst_n),
      .step_en  (step_en),
      .cnt      (cnt),
      .cnt_dn   (cnt_dn),
      .at_top   (at_top),
      .at_bot   (at_bot),
      .act_val  (act_val),
      .hold_val (hold_val),
      .pol_inv  (pol_inv),
      .ovf_clr  (ovf_clr),
      .cmp_clr  (cmp_clr),
      .pwm_pin  (pwm_pin),
      .ovf_flag (ovf_flag),
      .cmp_flag (cmp_flag)
   );

endmodule

// File: rtl/pcpwm_timer_chk.sv
`timescale 1ns/1ps
module pcpwm_timer_chk #(
   parameter int unsigned CNT_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             step_en,
   input logic [CNT_W-1:0] cnt,
   input logic             cnt_dn,
   input logic [CNT_W-1:0] act_val,
   input logic             pol_inv,
   input logic             pwm_pin,
   input logic             ovf_flag,
   input logic             cmp_flag
);

   localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

   AST_STEP_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      step_en |=> ((cnt == $past(cnt) + CNT_W'(1)) || (cnt == $past(cnt) - CNT_W'(1)))); // R3

   AST_HOLD_NO_EN: assert property (@(posedge clk) disable iff (!rst_n)
      !step_en |=> $stable(cnt)); // R1

   AST_LOAD_AT_TOP: assert property (@(posedge clk) disable iff (!rst_n)
      !(step_en && cnt == TOP) |=> $stable(act_val)); // R4

   AST_LOW_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (act_val == '0) |-> (pwm_pin == pol_inv)); // R6

   AST_HIGH_AT_TOP: assert property (@(posedge clk) disable iff (!rst_n)
      (act_val == TOP) |-> (pwm_pin == !pol_inv)); // R6

   AST_OVF_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      (step_en && cnt_dn && cnt == CNT_W'(1)) |=> ovf_flag); // R9

   AST_CMP_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      (step_en && cnt == act_val) |=> cmp_flag); // R10

endmodule

bind pcpwm_timer pcpwm_timer_chk #(.CNT_W(CNT_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .step_en  (step_en),
   .cnt      (cnt),
   .cnt_dn   (cnt_dn),
   .act_val  (act_val),
   .pol_inv  (pol_inv),
   .pwm_pin  (pwm_pin),
   .ovf_flag (ovf_flag),
   .cmp_flag (cmp_flag)
);

// File: tb/tb_pcpwm_timer.sv
`timescale 1ns/1ps
module tb_pcpwm_timer;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] presc_sel = 3'd0;
   logic       pol_inv = 1'b0;
   logic       cmp_we = 1'b0;
   logic [7:0] cmp_wdata = 8'd0;
   logic       ovf_clr = 1'b0;
   logic       cmp_clr = 1'b0;
   logic       pwm_pin;
   logic       ovf_flag;
   logic       cmp_flag;

   int total = 0;
   int bad = 0;
   bit finished = 0;

   // model state
   int m_c, m_v, m_buf, m_p, m_selq;
   bit m_dn, m_up, m_stepped, m_ovf, m_cmp;
   int cyc = 0;

   always #10 clk = ~clk;   // 50 MHz

   pcpwm_timer dut (
      .clk(clk), .rst_n(rst_n), .presc_sel(presc_sel), .pol_inv(pol_inv),
      .cmp_we(cmp_we), .cmp_wdata(cmp_wdata), .ovf_clr(ovf_clr), .cmp_clr(cmp_clr),
      .pwm_pin(pwm_pin), .ovf_flag(ovf_flag), .cmp_flag(cmp_flag)
   );

   function automatic int bdiv(input int code);
      case (code)
         1: return 1;
         2: return 8;
         3: return 64;
         4: return 256;
         5: return 1024;
         default: return 0;
      endcase
   endfunction

   function automatic bit exp_level();
      if (!m_stepped) return 1'b0;
      if (m_up) return (m_c <= m_v);
      return (m_c < m_v);
   endfunction

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         if (bad <= 20) $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
      end
   endtask

   task automatic model_reset();
      m_c = 0; m_v = 0; m_buf = 0; m_p = 0; m_selq = 0;
      m_dn = 0; m_up = 0; m_stepped = 0; m_ovf = 0; m_cmp = 0;
   endtask

   task automatic model_edge();
      int n;
      int nx;
      bit t, so, sc;
      n = bdiv(presc_sel);
      t = 0; so = 0; sc = 0;
      if (presc_sel != m_selq || n == 0) m_p = 0;
      else begin
         t = (m_p == n - 1);
         m_p = t ? 0 : m_p + 1;
      end
      m_selq = presc_sel;
      if (t) begin
         sc = (m_c == m_v);
         if (m_c == 255) m_v = m_buf;
         if (m_c == 255) begin nx = 254; m_dn = 1; end
         else if (m_c == 0) begin nx = 1; m_dn = 0; end
         else nx = m_dn ? m_c - 1 : m_c + 1;
         so = (nx == 0);
         m_up = (nx > m_c);
         m_c = nx;
         m_stepped = 1;
      end
      m_ovf = so ? 1'b1 : (ovf_clr ? 1'b0 : m_ovf);
      m_cmp = sc ? 1'b1 : (cmp_clr ? 1'b0 : m_cmp);
      if (cmp_we) m_buf = cmp_wdata;
   endtask

   // One clock: model follows the edge, outputs compared at the falling edge.
   task automatic run(input int n, input string tag);
      bit e;
      for (int i = 0; i < n; i++) begin
         @(posedge clk);
         model_edge();
         @(negedge clk);
         cyc++;
         e = exp_level() ^ pol_inv;
         chk(pwm_pin == e, tag, pwm_pin, e);
         chk(ovf_flag == m_ovf, "R9 R11 ovf_flag", ovf_flag, m_ovf);
         chk(cmp_flag == m_cmp, "R10 R11 cmp_flag", cmp_flag, m_cmp);
         cmp_we = 0; ovf_clr = 0; cmp_clr = 0;
      end
   endtask

   task automatic wr(input int v);
      cmp_we = 1; cmp_wdata = 8'(v);
   endtask

   task automatic measure(input int exp, input string tag);
      int t0;
      bit prev;
      prev = pwm_pin;
      while (!(pwm_pin && !prev)) begin prev = pwm_pin; run(1, tag); end
      t0 = cyc;
      prev = pwm_pin;
      run(1, tag);
      while (!(pwm_pin && !prev)) begin prev = pwm_pin; run(1, tag); end
      chk((cyc - t0) == exp, tag, cyc - t0, exp);
   endtask

   initial begin : watchdog
      #(20ns * 190000);
      if (!finished) begin
         total++; bad++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin : main
      void'($urandom(32'd20240611));
      model_reset();
      repeat (3) @(negedge clk);
      // R12: reset state
      chk(pwm_pin == 1'b0, "R12 pin in reset", pwm_pin, 0);
      chk(ovf_flag == 1'b0, "R12 ovf in reset", ovf_flag, 0);
      chk(cmp_flag == 1'b0, "R12 cmp in reset", cmp_flag, 0);
      rst_n = 1;
      presc_sel = 3'd1;
      wr(100);
      run(1100, "R4 R5 pin basic");

      // R3: period at divide-by-1 and divide-by-8
      wr(77); run(600, "R4");
      measure(510, "R3 period div1");
      presc_sel = 3'd2;
      measure(4080, "R3 period div8");
      presc_sel = 3'd1;

      // R6 extremes, R8 move away from 255
      wr(0);   run(1100, "R6 value 0 low");
      wr(255); run(1100, "R6 value 255 high");
      wr(40);  run(1100, "R8 leave 255");
      wr(255); run(600, "R6");
      wr(254); run(1100, "R8 to 254");
      wr(1);   run(1100, "R5 value 1");
      // R7 inverted, including extremes
      pol_inv = 1; run(3, "R7 immediate");
      wr(0);   run(1100, "R7 inverted 0");
      wr(255); run(1100, "R7 inverted 255");
      wr(128); run(1100, "R7 inverted mid");
      pol_inv = 0;
      // R11 clear pulses
      ovf_clr = 1; cmp_clr = 1; run(1, "R11");
      run(300, "R11");
      // R2 divider restart, R1 slow and stopped codes
      presc_sel = 3'd5; run(3000, "R1 R2 div1024");
      presc_sel = 3'd0; run(200, "R1 hold");
      presc_sel = 3'd3; run(2000, "R1 R2 div64");
      presc_sel = 3'd7; run(100, "R1 hold code7");
      presc_sel = 3'd1;

      // constrained random segments
      for (int s = 0; s < 40; s++) begin
         int r, len;
         r = $urandom % 100;
         if (r < 70) presc_sel = 3'd1;
         else if (r < 85) presc_sel = 3'd2;
         else if (r < 90) presc_sel = 3'd3;
         else if (r < 95) presc_sel = 3'(($urandom % 2) ? 0 : 6);
         else presc_sel = 3'(4 + $urandom % 2);
         len = 400 + $urandom % 800;
         for (int k = 0; k < len; k++) begin
            if ($urandom % 300 == 0) begin
               r = $urandom % 10;
               wr(r < 2 ? 0 : (r < 4 ? 255 : (r < 5 ? 254 : $urandom % 256)));
            end
            if ($urandom % 150 == 0) ovf_clr = 1;
            if ($urandom % 150 == 0) cmp_clr = 1;
            if ($urandom % 500 == 0) pol_inv = ~pol_inv;
            run(1, "R5 R7 R8 random");
         end
      end

      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule